// File: doc/BRIEF.md
# Protocol-Event Countdown Timer

This block is a 16-bit down-counter for the digital side of a contactless card reader. The host programs it through a small byte-wide register window: one control byte, two reload bytes and a status byte. A start event copies the 16-bit reload value into the counter. After that, the counter steps down once for each enable pulse of the count source chosen in the control byte. The source can be a base-rate tick, a slow tick, or the one-cycle underflow pulse of either of two sibling timers, so timers can be chained.

A start event can be a host start strobe. When the control byte selects it, the end of a transmitted frame is also a start event. In that mode the timer can stop by itself once the first four bits of the answering frame have arrived, so it measures the response time. On underflow the block sets a sticky interrupt flag and emits a one-cycle underflow pulse for its siblings. Two measurement modes arm the timer with the host start strobe. The first rising edge of a measured signal then loads and starts the counter, and the next rising edge freezes it. One of these modes saturates at zero silently; the other raises underflows.

A four-state machine controls the block:
- IDLE: the counter holds its value.
- COUNT: protocol or host-started counting.
- TRIM_ARM: waiting for the first rising edge of the measured signal.
- TRIM_MEAS: measuring.

The transitions are:
- IDLE/COUNT to COUNT on a start event in a non-measurement mode (load).
- IDLE/COUNT to TRIM_ARM on a host start in a measurement mode (arm).
- TRIM_ARM to TRIM_MEAS on a rising edge of the measured signal (load).
- TRIM_MEAS to IDLE on the next rising edge (freeze).
- COUNT to IDLE on underflow without auto-restart (expire).
- COUNT to IDLE on the fourth received bit with receive-stop enabled (rx stop).
- Any state to IDLE on the host stop strobe (abort).

Top module: `rdr_countdown_timer`

## Requirements
- R1: Control bits 1:0 pick the count source: 00 `tick_base`, 01 `tick_slow`, 10 `uf_t0`, 11 `uf_t2`. The count drops by one per pulse of the selected source only; pulses on the other three have no effect.
- R2: `sw_start` is always a start event. `tx_done` is a start event only when control bits 5:4 are 01; with any other value it is ignored. In modes 00 and 01 a start event loads the counter and enters COUNT.
- R3: The reload value is {byte at address 1, byte at address 2}. It is copied into the counter, and into a private copy used for auto-restart, only at a start event. Writes to the reload bytes while running take effect from the next start.
- R4: A selected tick is an underflow when the count is 1, or when the count is 0 in COUNT. On an underflow the interrupt flag sets and `uf_pulse` is high for that one cycle. With control bit 3 clear, a COUNT-state underflow leaves the count at 0 and returns to IDLE.
- R5: With control bit 3 set, an underflow reloads the counter from the private reload copy and counting continues.
- R6: With control bit 7 set in a non-measurement mode, the fourth `rx_bit` pulse since the start stops the timer with the count held. With bit 7 clear, `rx_bit` never stops it.
- R7: Control bits 5:4 equal to 10 or 11 select measurement. `sw_start` arms the timer. The first rising edge of `trim_sig` loads the reload value and starts counting, and the next rising edge stops it with the count held. Control bit 7 has no effect in these modes.
- R8: In measurement mode 10 the count saturates at 0 and never raises an underflow or the interrupt flag. In mode 11 underflows are raised as in R4, but the timer keeps measuring.
- R9: The interrupt flag (`irq`, status bit 0 at address 3) stays set until the host writes a 1 to status bit 0. Writing 0 has no effect. A set in the same cycle wins over a clear. Status bit 1 reads as the running bit.
- R10: Control bits 6 and 2 are reserved: they are not stored and read back as 0.
- R11: `sw_stop` returns the timer to IDLE from any state with the count held. In IDLE, ticks do not change the count.
- R12: After reset the count, flag, pulse, running bit and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 reload high, 2 reload low, 3 status) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| sw_start | input | 1 | Host start strobe |
| sw_stop | input | 1 | Host stop strobe |
| tx_done | input | 1 | End-of-transmit strobe |
| rx_bit | input | 1 | One pulse per received bit |
| trim_sig | input | 1 | Signal measured in the measurement modes |
| tick_base | input | 1 | Base-rate count enable |
| tick_slow | input | 1 | Slow count enable |
| uf_t0 | input | 1 | Underflow pulse of sibling timer 0 |
| uf_t2 | input | 1 | Underflow pulse of sibling timer 2 |
| count | output | 16 | Current counter value |
| running | output | 1 | High whenever the state is not IDLE |
| uf_pulse | output | 1 | One-cycle underflow pulse |
| irq | output | 1 | Sticky interrupt flag |

## Verification
Every strobe, tick and register write is sampled on a rising clock edge. Its effect on `count`, `running`, `irq` and `uf_pulse` is therefore due on that same edge, one cycle after the input is presented. `rd_data` follows `rd_addr` with no delay. The bench changes inputs on the falling edge and holds each pulse for exactly one rising edge. It samples results at the next falling edge, so each check lands in the first cycle its result is due, and `uf_pulse` is checked both in that cycle and in the one after. A stimulus table walks load, expire and auto-restart cases. Directed tests cover source selection, reload latching, receive stop, both measurement modes, flag clearing and reserved bits.

// File: rtl/rdr_tmr_pkg.sv
package rdr_tmr_pkg;

    localparam int TMR_BYTE_W  = 8;
    localparam int TMR_CNT_W   = 2 * TMR_BYTE_W;
    localparam int TMR_ADDR_W  = 2;
    localparam int NUM_CLK_SRC = 4;
    localparam int CLK_SEL_W   = $clog2(NUM_CLK_SRC);

    localparam logic [TMR_ADDR_W-1:0] ADDR_CTL    = 2'd0;
    localparam logic [TMR_ADDR_W-1:0] ADDR_RLD_HI = 2'd1;
    localparam logic [TMR_ADDR_W-1:0] ADDR_RLD_LO = 2'd2;
    localparam logic [TMR_ADDR_W-1:0] ADDR_STAT   = 2'd3;

    // Bits 6 and 2 of the control byte are reserved and never stored.
    localparam logic [TMR_BYTE_W-1:0] CTL_WR_MASK = 8'hBB;

    typedef enum logic [CLK_SEL_W-1:0] {
        CLK_BASE  = 2'b00,
        CLK_SLOW  = 2'b01,
        CLK_CASC0 = 2'b10,
        CLK_CASC2 = 2'b11
    } clk_sel_e;

    typedef enum logic [1:0] {
        START_SW_ONLY   = 2'b00,
        START_TX_END    = 2'b01,
        START_TRIM_NOUF = 2'b10,
        START_TRIM_UF   = 2'b11
    } start_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_TRIM_ARM,
        ST_TRIM_MEAS
    } tmr_state_e;

    typedef struct packed {
        logic        rx_stop;
        logic        rsvd6;
        start_mode_e start_mode;
        logic        auto_rst;
        logic        rsvd2;
        clk_sel_e    clk_sel;
    } ctl_t;

endpackage

// File: rtl/rdr_tmr_regs.sv
module rdr_tmr_regs
    import rdr_tmr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TMR_ADDR_W-1:0] wr_addr,
    input  logic [TMR_BYTE_W-1:0] wr_data,
    input  logic [TMR_ADDR_W-1:0] rd_addr,
    output logic [TMR_BYTE_W-1:0] rd_data,
    input  logic                  irq_set,
    input  logic                  running,
    output ctl_t                  ctl,
    output logic [TMR_CNT_W-1:0]  reload,
    output logic                  irq
);

    ctl_t                  ctl_q;
    logic [TMR_BYTE_W-1:0] rld_hi_q;
    logic [TMR_BYTE_W-1:0] rld_lo_q;
    logic                  irq_q;
    logic                  irq_clr;

    assign irq_clr = wr_en && (wr_addr == ADDR_STAT) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            rld_hi_q <= '0;
            rld_lo_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTL:    ctl_q    <= ctl_t'(wr_data & CTL_WR_MASK);
                ADDR_RLD_HI: rld_hi_q <= wr_data;
                ADDR_RLD_LO: rld_lo_q <= wr_data;
                ADDR_STAT:   ;
            endcase
        end
    end

    // Sticky flag: a set in the same cycle wins over a host clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (irq_set) begin
            irq_q <= 1'b1;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CTL:    rd_data = ctl_q;
            ADDR_RLD_HI: rd_data = rld_hi_q;
            ADDR_RLD_LO: rd_data = rld_lo_q;
            ADDR_STAT:   rd_data = {{(TMR_BYTE_W-2){1'b0}}, running, irq_q};
        endcase
    end

    assign ctl    = ctl_q;
    assign reload = {rld_hi_q, rld_lo_q};
    assign irq    = irq_q;

    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !irq_set) |=> !irq_q); // R9

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr) |=> irq_q); // R9

endmodule

// File: rtl/rdr_tmr_tick_sel.sv
module rdr_tmr_tick_sel
    import rdr_tmr_pkg::*;
(
    input  clk_sel_e sel,
    input  logic     tick_base,
    input  logic     tick_slow,
    input  logic     uf_t0,
    input  logic     uf_t2,
    output logic     tick
);

    logic [NUM_CLK_SRC-1:0] src;
    logic [NUM_CLK_SRC-1:0] hit;

    // Source index equals the select code.
    assign src = {uf_t2, uf_t0, tick_slow, tick_base};

    for (genvar g = 0; g < NUM_CLK_SRC; g++) begin : g_src
        assign hit[g] = src[g] && (sel == clk_sel_e'(CLK_SEL_W'(g)));
    end

    assign tick = |hit;

endmodule

// File: rtl/rdr_tmr_fsm.sv
module rdr_tmr_fsm
    import rdr_tmr_pkg::*;
#(
    parameter int RX_STOP_BITS = 4,
    localparam int RXC_W = $clog2(RX_STOP_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_stop_en,
    input  start_mode_e          start_mode,
    input  logic                 auto_rst,
    input  logic [TMR_CNT_W-1:0] reload,
    input  logic                 tick,
    input  logic                 sw_start,
    input  logic                 sw_stop,
    input  logic                 tx_done,
    input  logic                 rx_bit,
    input  logic                 trim_sig,
    output logic [TMR_CNT_W-1:0] count,
    output logic                 running,
    output logic                 uf_pulse,
    output logic                 irq_set
);

    localparam logic [RXC_W-1:0]     RX_LAST = RXC_W'(RX_STOP_BITS - 1);
    localparam logic [TMR_CNT_W-1:0] CNT_ONE = TMR_CNT_W'(1);

    tmr_state_e           state_q, state_d;
    logic [TMR_CNT_W-1:0] cnt_q, cnt_d;
    logic [TMR_CNT_W-1:0] rld_q, rld_d;
    logic [RXC_W-1:0]     rxc_q, rxc_d;
    logic                 uf_q, uf_d;
    logic                 trim_q;
    logic                 trim_rise;
    logic                 trim_mode;
    logic                 start_evt;
    logic                 rx_stop_now;

    assign trim_mode   = start_mode[1];
    assign trim_rise   = trim_sig && !trim_q;
    assign start_evt   = sw_start || (tx_done && (start_mode == START_TX_END));
    assign rx_stop_now = rx_stop_en && !trim_mode && rx_bit && (rxc_q == RX_LAST);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rld_q  <= '0;
            rxc_q  <= '0;
            uf_q   <= 1'b0;
            trim_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            rld_q  <= rld_d;
            rxc_q  <= rxc_d;
            uf_q   <= uf_d;
            trim_q <= trim_sig;
        end
    end

    // Next state and datapath.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rld_d   = rld_q;
        rxc_d   = rxc_q;
        uf_d    = 1'b0;

        unique case (state_q)
            ST_IDLE, ST_COUNT: begin
                if (sw_stop) begin
                    state_d = ST_IDLE;                       // abort
                end else if (start_evt && trim_mode) begin
                    state_d = ST_TRIM_ARM;                   // arm
                end else if (start_evt) begin
                    state_d = ST_COUNT;                      // load
                    cnt_d   = reload;
                    rld_d   = reload;
                    rxc_d   = '0;
                end else if (state_q == ST_COUNT) begin
                    if (rx_stop_now) begin
                        state_d = ST_IDLE;                   // rx stop
                    end else begin
                        if (rx_bit && (rxc_q != RX_LAST)) begin
                            rxc_d = rxc_q + RXC_W'(1);
                        end
                        if (tick) begin
                            if (cnt_q <= CNT_ONE) begin
                                uf_d = 1'b1;
                                if (auto_rst) begin
                                    cnt_d = rld_q;
                                end else begin
                                    cnt_d   = '0;
                                    state_d = ST_IDLE;       // expire
                                end
                            end else begin
                                cnt_d = cnt_q - CNT_ONE;
                            end
                        end
                    end
                end
            end

            ST_TRIM_ARM: begin
                if (sw_stop) begin
                    state_d = ST_IDLE;                       // abort
                end else if (trim_rise) begin
                    state_d = ST_TRIM_MEAS;                  // load
                    cnt_d   = reload;
                    rld_d   = reload;
                end
            end

            ST_TRIM_MEAS: begin
                if (sw_stop || trim_rise) begin
                    state_d = ST_IDLE;                       // abort / freeze
                end else if (tick) begin
                    if (start_mode == START_TRIM_UF &&
                        ((cnt_q == CNT_ONE) || (cnt_q == '0 && auto_rst))) begin
                        uf_d  = 1'b1;
                        cnt_d = auto_rst ? rld_q : '0;
                    end else if (cnt_q != '0) begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end
            end
        endcase
    end

    // Outputs.
    always_comb begin
        count    = cnt_q;
        running  = (state_q != ST_IDLE);
        uf_pulse = uf_q;
        irq_set  = uf_d;
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> $stable(cnt_q)); // R11

    AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && tick && cnt_q == CNT_ONE && !auto_rst && !sw_stop
         && !start_evt && !rx_stop_now) |=> (state_q == ST_IDLE && cnt_q == '0 && uf_q)); // R4

    AST_AUTO_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && tick && cnt_q == CNT_ONE && auto_rst && !sw_stop
         && !start_evt && !rx_stop_now) |=> (state_q == ST_COUNT && cnt_q == $past(rld_q))); // R5

    AST_RX_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && rx_stop_now && !sw_stop && !start_evt)
        |=> (state_q == ST_IDLE && $stable(cnt_q))); // R6

    AST_TRIM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIM_MEAS && start_mode == START_TRIM_NOUF) |=> !uf_q); // R8

endmodule

// File: rtl/rdr_countdown_timer.sv
module rdr_countdown_timer
    import rdr_tmr_pkg::*;
#(
    parameter int RX_STOP_BITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TMR_ADDR_W-1:0] wr_addr,
    input  logic [TMR_BYTE_W-1:0] wr_data,
    input  logic [TMR_ADDR_W-1:0] rd_addr,
    output logic [TMR_BYTE_W-1:0] rd_data,
    input  logic                  sw_start,
    input  logic                  sw_stop,
    input  logic                  tx_done,
    input  logic                  rx_bit,
    input  logic                  trim_sig,
    input  logic                  tick_base,
    input  logic                  tick_slow,
    input  logic                  uf_t0,
    input  logic                  uf_t2,
    output logic [TMR_CNT_W-1:0]  count,
    output logic                  running,
    output logic                  uf_pulse,
    output logic                  irq
);

    ctl_t                 ctl;
    logic [TMR_CNT_W-1:0] reload;
    logic                 tick;
    logic                 irq_set;

    rdr_tmr_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq_set (irq_set),
        .running (running),
        .ctl     (ctl),
        .reload  (reload),
        .irq     (irq)
    );

    rdr_tmr_tick_sel u_tick_sel (
        .sel       (ctl.clk_sel),
        .tick_base (tick_base),
        .tick_slow (tick_slow),
        .uf_t0     (uf_t0),
        .uf_t2     (uf_t2),
        .tick      (tick)
    );

    rdr_tmr_fsm #(
        .RX_STOP_BITS (RX_STOP_BITS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_stop_en (ctl.rx_stop),
        .start_mode (ctl.start_mode),
        .auto_rst   (ctl.auto_rst),
        .reload     (reload),
        .tick       (tick),
        .sw_start   (sw_start),
        .sw_stop    (sw_stop),
        .tx_done    (tx_done),
        .rx_bit     (rx_bit),
        .trim_sig   (trim_sig),
        .count      (count),
        .running    (running),
        .uf_pulse   (uf_pulse),
        .irq_set    (irq_set)
    );

    AST_UF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        uf_pulse |-> irq); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_CTL) |-> (rd_data[6] == 1'b0 && rd_data[2] == 1'b0)); // R10

    AST_NO_TX_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && tx_done && !sw_start && ctl.start_mode != START_TX_END) |=> !running); // R2

endmodule

// File: tb/rdr_countdown_timer_bench.sv
module rdr_countdown_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        sw_start = 1'b0, sw_stop = 1'b0, tx_done = 1'b0, rx_bit = 1'b0;
    logic        trim_sig = 1'b0;
    logic        tick_base = 1'b0, tick_slow = 1'b0, uf_t0 = 1'b0, uf_t2 = 1'b0;
    logic [15:0] count;
    logic        running, uf_pulse, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;   // 10 ns period, 100 MHz

    rdr_countdown_timer u_rdr_countdown_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sw_start(sw_start), .sw_stop(sw_stop),
        .tx_done(tx_done), .rx_bit(rx_bit), .trim_sig(trim_sig), .tick_base(tick_base),
        .tick_slow(tick_slow), .uf_t0(uf_t0), .uf_t2(uf_t2), .count(count),
        .running(running), .uf_pulse(uf_pulse), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  ctl;
        logic [15:0] rld;
        logic [7:0]  nticks;
        logic [15:0] exp_cnt;
        logic        exp_irq;
        logic        exp_run;
    } vec_t;

    // ctl, reload, slow ticks, expected count, irq, running
    localparam vec_t VECS [6] = '{
        '{8'h01, 16'd10,  8'd3, 16'd7,   1'b0, 1'b1},  // plain count
        '{8'h01, 16'd5,   8'd5, 16'd0,   1'b1, 1'b0},  // expire
        '{8'h09, 16'd5,   8'd5, 16'd5,   1'b1, 1'b1},  // auto-restart at edge
        '{8'h09, 16'd4,   8'd6, 16'd2,   1'b1, 1'b1},  // auto-restart then count
        '{8'h01, 16'd0,   8'd1, 16'd0,   1'b1, 1'b0},  // zero reload
        '{8'h01, 16'd300, 8'd0, 16'd300, 1'b0, 1'b1}   // load only
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_reload(input logic [15:0] v);
        wr(2'd1, v[15:8]);
        wr(2'd2, v[7:0]);
    endtask

    task automatic pulse_start();
        @(negedge clk); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); sw_stop = 1'b1; @(negedge clk); sw_stop = 1'b0;
    endtask

    task automatic pulse_tx();
        @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic pulse_rx();
        @(negedge clk); rx_bit = 1'b1; @(negedge clk); rx_bit = 1'b0;
    endtask

    // which: 0 base, 1 slow, 2 sibling 0, 3 sibling 2
    task automatic ticks(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_base = (which == 0); tick_slow = (which == 1);
            uf_t0 = (which == 2); uf_t2 = (which == 3);
            @(negedge clk);
            tick_base = 1'b0; tick_slow = 1'b0; uf_t0 = 1'b0; uf_t2 = 1'b0;
        end
    endtask

    task automatic trim_edge();
        @(negedge clk); trim_sig = 1'b1;
        @(negedge clk);
        @(negedge clk); trim_sig = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk("R12 count", count, 0);
        chk("R12 irq", irq, 0);
        chk("R12 running", running, 0);
        chk("R12 uf_pulse", uf_pulse, 0);
        rd_addr = 2'd0; #1;
        chk("R12 ctl read", rd_data, 0);

        // Table walk: R1 R4 R5 over slow tick
        for (int v = 0; v < 6; v++) begin
            pulse_stop();
            wr(2'd0, VECS[v].ctl);
            set_reload(VECS[v].rld);
            wr(2'd3, 8'h01);
            pulse_start();
            ticks(1, int'(VECS[v].nticks));
            chk($sformatf("R4/R5 vec%0d count", v), count, VECS[v].exp_cnt);
            chk($sformatf("R4/R9 vec%0d irq", v), irq, VECS[v].exp_irq);
            chk($sformatf("R4/R5 vec%0d running", v), running, VECS[v].exp_run);
        end

        // R10: reserved bits read as zero
        wr(2'd0, 8'hFF);
        rd_addr = 2'd0; #1;
        chk("R10 ctl readback", rd_data, 8'hBB);

        // R2: transmit end starts only in mode 01
        pulse_stop();
        wr(2'd0, 8'h01);
        set_reload(16'd20);
        pulse_tx();
        chk("R2 tx ignored", running, 0);
        wr(2'd0, 8'h11);
        pulse_tx();
        chk("R2 tx start running", running, 1);
        chk("R2 tx start count", count, 20);

        // R3: reload latched only at start
        pulse_stop();
        wr(2'd0, 8'h09);
        set_reload(16'd3);
        pulse_start();
        wr(2'd2, 8'd50);
        ticks(1, 3);
        chk("R3 auto reload uses latched", count, 3);
        pulse_start();
        chk("R3 new reload at start", count, 50);

        // R1: source selection
        pulse_stop();
        wr(2'd0, 8'h00);
        set_reload(16'd10);
        pulse_start();
        @(negedge clk);
        tick_slow = 1'b1; uf_t0 = 1'b1; uf_t2 = 1'b1;
        @(negedge clk);
        tick_slow = 1'b0; uf_t0 = 1'b0; uf_t2 = 1'b0;
        chk("R1 unselected ignored", count, 10);
        ticks(0, 1);
        chk("R1 base tick", count, 9);
        wr(2'd0, 8'h02);
        ticks(2, 1);
        chk("R1 sibling0 tick", count, 8);
        ticks(0, 1);
        chk("R1 base ignored when sibling0", count, 8);
        wr(2'd0, 8'h03);
        ticks(3, 1);
        chk("R1 sibling2 tick", count, 7);

        // R4: underflow pulse is one cycle
        pulse_stop();
        wr(2'd0, 8'h01);
        set_reload(16'd2);
        wr(2'd3, 8'h01);
        pulse_start();
        ticks(1, 1);
        chk("R4 no pulse before zero", uf_pulse, 0);
        @(negedge clk); tick_slow = 1'b1;
        @(negedge clk); tick_slow = 1'b0;
        chk("R4 pulse on underflow", uf_pulse, 1);
        chk("R4 expire stops", running, 0);
        @(negedge clk);
        chk("R4 pulse one cycle", uf_pulse, 0);

        // R9: flag clear only by writing 1
        wr(2'd3, 8'h00);
        chk("R9 write 0 keeps flag", irq, 1);
        wr(2'd3, 8'h01);
        chk("R9 write 1 clears flag", irq, 0);

        // R6: receive stop after four bits
        pulse_stop();
        wr(2'd0, 8'h81);
        set_reload(16'd100);
        pulse_start();
        for (int i = 0; i < 3; i++) pulse_rx();
        chk("R6 three bits keep running", running, 1);
        pulse_rx();
        chk("R6 fourth bit stops", running, 0);
        chk("R6 count held", count, 100);
        wr(2'd0, 8'h01);
        pulse_start();
        for (int i = 0; i < 4; i++) pulse_rx();
        chk("R6 bit7 clear no stop", running, 1);

        // R7 R8: measurement without underflow, bit 7 set
        pulse_stop();
        wr(2'd0, 8'hA1);
        set_reload(16'd3);
        wr(2'd3, 8'h01);
        pulse_start();
        chk("R7 armed running", running, 1);
        trim_edge();
        chk("R7 first edge loads", count, 3);
        for (int i = 0; i < 4; i++) pulse_rx();
        chk("R7 bit7 ignored in trim", running, 1);
        ticks(1, 5);
        chk("R8 saturates at zero", count, 0);
        chk("R8 no irq", irq, 0);
        trim_edge();
        chk("R7 second edge stops", running, 0);

        // R7: measurement with underflow mode, frozen count
        wr(2'd0, 8'h31);
        set_reload(16'd100);
        pulse_start();
        trim_edge();
        ticks(1, 7);
        trim_edge();
        chk("R7 measured count", count, 93);
        chk("R7 frozen", running, 0);
        set_reload(16'd2);
        wr(2'd3, 8'h01);
        pulse_start();
        trim_edge();
        ticks(1, 2);
        chk("R8 mode 11 raises irq", irq, 1);
        chk("R8 mode 11 keeps measuring", running, 1);
        trim_edge();

        // R11: host stop holds count
        wr(2'd0, 8'h01);
        set_reload(16'd9);
        pulse_start();
        ticks(1, 2);
        pulse_stop();
        chk("R11 stopped", running, 0);
        ticks(1, 1);
        chk("R11 count held", count, 7);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule